// File: doc/BRIEF.md
# Auxiliary-Mode PWM Timer

This block is a timer that generates a single pulse-width-modulated output. A counter starts at zero and counts up. It is compared against an active period value and an active compare value. When the counter reaches the period, it returns to zero on the next clock. The output is high for the part of each period in which the counter is below the compare value. A control register sets whether the counter runs, whether the output is enabled, whether the output is inverted, and whether an external synchronisation pulse may restart the count.

Each of the period and compare values has a shadow copy. Software may rewrite the shadows at any time. The shadows are transferred to the active values only at the clock on which the counter wraps, so a period that is in progress always finishes with the values it began with. Writing an active register takes effect on the next clock, which suits configuration while the counter is stopped. The same write also sets the matching shadow, so that the next wrap does not discard the new value.

Access is through a simple synchronous bus: address, write strobe, byte-lane enables, write data, and combinational read data.

Top module: `aux_pwm_timer`

## Requirements
- R1: After reset, every register reads 0, the counter is 0 and stopped, and `pwm_out` is low.
- R2: Registers sit at byte offsets 0x00 control, 0x04 active period, 0x08 active compare, 0x0C shadow period, 0x10 shadow compare and 0x14 counter (read-only). A write changes only the bytes whose enable bit is set (bit i covers data bits 8i+7:8i). Control keeps only bits 0, 1, 2, 4 and 5; its other bits read 0. Unmapped offsets read 0.
- R3: The counter advances by one on each clock while control bit 0 (run) is 1. It holds its value while run is 0.
- R4: While running, the counter goes 0, 1, …, P and then returns to 0, where P is the active period. A period value of P therefore spans P+1 clocks. If the counter is ever at or above P, it returns to 0 on the next clock.
- R5: With control bit 1 (output enable) set and control bit 2 (invert) clear, `pwm_out` is high while the counter is below the active compare value C and low otherwise. If C ≥ P, the output is constantly high.
- R6: With control bit 2 set, `pwm_out` is the complement of the R5 level, so C sets the low time.
- R7: With control bit 1 clear, `pwm_out` is low regardless of the invert bit.
- R8: A write to a shadow register leaves the active period and compare unchanged until the clock on which the running counter wraps. On that clock, both active registers take the shadow values.
- R9: A write to an active register takes effect on the next clock, and the same write also places the merged value in the matching shadow register.
- R10: While running, a high `sync_in` clears the counter on the next clock if control bits 5:4 are not both 1. If control bits 5:4 are 2'b11, `sync_in` is ignored.
- R11: The smallest setting, period 1 with compare 1, gives a counter that alternates 0, 1 and an output that stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_strb | input | DATA_W/8 | Byte-lane enables for writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| sync_in | input | 1 | External counter restart pulse |
| pwm_out | output | 1 | PWM output |

## Verification
Most faults show within one period at the ports. A counter that skips, sticks or wraps at the wrong value shows up as a high or low time of the wrong length on `pwm_out`, and as a wrong value in the counter register on the next bus read. A shadow transfer that happens too early shortens the period in progress. A missed transfer keeps the old duty after the wrap. Either way, the wrong value appears in the active registers within one clock of the wrap. A sync pulse that is wrongly honoured or wrongly ignored changes the counter read on the very next clock.

// File: rtl/aux_pwm_pkg.sv
package aux_pwm_pkg;
  localparam int unsigned OFF_CTRL    = 'h00;
  localparam int unsigned OFF_PER_ACT = 'h04;
  localparam int unsigned OFF_CMP_ACT = 'h08;
  localparam int unsigned OFF_PER_SH  = 'h0C;
  localparam int unsigned OFF_CMP_SH  = 'h10;
  localparam int unsigned OFF_COUNT   = 'h14;

  localparam int unsigned CTRL_W       = 16;
  localparam int unsigned BIT_RUN      = 0;
  localparam int unsigned BIT_PWM_EN   = 1;
  localparam int unsigned BIT_INVERT   = 2;
  localparam int unsigned BIT_SYNC_LO  = 4;
  localparam int unsigned BIT_SYNC_HI  = 5;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 16'h0037;
endpackage

// File: rtl/aux_pwm_regs.sv
module aux_pwm_regs
  import aux_pwm_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr,
  input  logic [DATA_W/8-1:0] strb,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                wrap,
  input  logic [DATA_W-1:0]   cnt,
  output logic [DATA_W-1:0]   rdata,
  output logic                run,
  output logic                pwm_en,
  output logic                invert,
  output logic [1:0]          sync_sel,
  output logic [DATA_W-1:0]   per_act,
  output logic [DATA_W-1:0]   cmp_act,
  output logic [DATA_W-1:0]   per_sh,
  output logic [DATA_W-1:0]   cmp_sh
);
  localparam int unsigned NB = DATA_W / 8;

  logic [DATA_W-1:0] wmask;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] per_act_q, per_act_d, cmp_act_q, cmp_act_d;
  logic [DATA_W-1:0] per_sh_q, per_sh_d, cmp_sh_q, cmp_sh_d;
  logic sel_ctrl, sel_pa, sel_ca, sel_ps, sel_cs;
  logic en_ctrl, en_act, en_sh;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign wmask[b*8 +: 8] = {8{strb[b]}};
  end

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old_v,
                                              input logic [DATA_W-1:0] new_v,
                                              input logic [DATA_W-1:0] m);
    return (old_v & ~m) | (new_v & m);
  endfunction

  assign sel_ctrl = wr && (addr == ADDR_W'(OFF_CTRL));
  assign sel_pa   = wr && (addr == ADDR_W'(OFF_PER_ACT));
  assign sel_ca   = wr && (addr == ADDR_W'(OFF_CMP_ACT));
  assign sel_ps   = wr && (addr == ADDR_W'(OFF_PER_SH));
  assign sel_cs   = wr && (addr == ADDR_W'(OFF_CMP_SH));

  always_comb begin
    ctrl_d = ((ctrl_q & ~wmask[CTRL_W-1:0]) | (wdata[CTRL_W-1:0] & wmask[CTRL_W-1:0]))
             & CTRL_MASK;
    per_act_d = per_act_q;
    cmp_act_d = cmp_act_q;
    if (wrap) begin
      per_act_d = per_sh_q;
      cmp_act_d = cmp_sh_q;
    end
    if (sel_pa) per_act_d = merge(per_act_q, wdata, wmask);
    if (sel_ca) cmp_act_d = merge(cmp_act_q, wdata, wmask);
    per_sh_d = per_sh_q;
    cmp_sh_d = cmp_sh_q;
    if (sel_ps) per_sh_d = merge(per_sh_q, wdata, wmask);
    if (sel_pa) per_sh_d = merge(per_act_q, wdata, wmask);
    if (sel_cs) cmp_sh_d = merge(cmp_sh_q, wdata, wmask);
    if (sel_ca) cmp_sh_d = merge(cmp_act_q, wdata, wmask);
  end

  assign en_ctrl = sel_ctrl;
  assign en_act  = wrap | sel_pa | sel_ca;
  assign en_sh   = sel_ps | sel_cs | sel_pa | sel_ca;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (en_ctrl) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_act_q <= '0;
      cmp_act_q <= '0;
    end else if (en_act) begin
      per_act_q <= per_act_d;
      cmp_act_q <= cmp_act_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_sh_q <= '0;
      cmp_sh_q <= '0;
    end else if (en_sh) begin
      per_sh_q <= per_sh_d;
      cmp_sh_q <= cmp_sh_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(OFF_CTRL):    rdata = DATA_W'(ctrl_q);
      ADDR_W'(OFF_PER_ACT): rdata = per_act_q;
      ADDR_W'(OFF_CMP_ACT): rdata = cmp_act_q;
      ADDR_W'(OFF_PER_SH):  rdata = per_sh_q;
      ADDR_W'(OFF_CMP_SH):  rdata = cmp_sh_q;
      ADDR_W'(OFF_COUNT):   rdata = cnt;
      default:              rdata = '0;
    endcase
  end

  assign run      = ctrl_q[BIT_RUN];
  assign pwm_en   = ctrl_q[BIT_PWM_EN];
  assign invert   = ctrl_q[BIT_INVERT];
  assign sync_sel = ctrl_q[BIT_SYNC_HI:BIT_SYNC_LO];
  assign per_act  = per_act_q;
  assign cmp_act  = cmp_act_q;
  assign per_sh   = per_sh_q;
  assign cmp_sh   = cmp_sh_q;
endmodule

// File: rtl/aux_pwm_counter.sv
module aux_pwm_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             sync_in,
  input  logic [1:0]       sync_sel,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sync_hit;

  assign sync_hit = sync_in && (sync_sel != 2'b11);
  assign wrap     = run && (cnt_q >= period);

  always_comb begin
    if (wrap || sync_hit) cnt_d = '0;
    else                  cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (run) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/aux_pwm_out.sv
module aux_pwm_out #(
  parameter int unsigned CNT_W = 32
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] compare,
  input  logic             pwm_en,
  input  logic             invert,
  output logic             pwm
);
  logic level;

  always_comb begin
    level = (compare >= period) || (cnt < compare);
    pwm   = pwm_en && (level ^ invert);
  end
endmodule

// File: rtl/aux_pwm_timer.sv
module aux_pwm_timer #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [DATA_W/8-1:0] bus_strb,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                sync_in,
  output logic                pwm_out
);
  localparam int unsigned CNT_W = DATA_W;

  logic             rst_meta, rst_sync_n;
  logic             run, pwm_en, invert, wrap;
  logic [1:0]       sync_sel;
  logic [CNT_W-1:0] cnt, per_act, cmp_act, per_sh, cmp_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  aux_pwm_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .addr(bus_addr), .wr(bus_wr), .strb(bus_strb),
    .wdata(bus_wdata), .wrap(wrap), .cnt(cnt), .rdata(bus_rdata), .run(run),
    .pwm_en(pwm_en), .invert(invert), .sync_sel(sync_sel), .per_act(per_act),
    .cmp_act(cmp_act), .per_sh(per_sh), .cmp_sh(cmp_sh)
  );

  aux_pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .run(run), .sync_in(sync_in),
    .sync_sel(sync_sel), .period(per_act), .cnt(cnt), .wrap(wrap)
  );

  aux_pwm_out #(.CNT_W(CNT_W)) u_out (
    .cnt(cnt), .period(per_act), .compare(cmp_act), .pwm_en(pwm_en),
    .invert(invert), .pwm(pwm_out)
  );
endmodule

// File: rtl/aux_pwm_checker.sv
module aux_pwm_checker
  import aux_pwm_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   addr,
  input logic                wr,
  input logic [DATA_W/8-1:0] strb,
  input logic [DATA_W-1:0]   wdata,
  input logic                run,
  input logic                pwm_en,
  input logic [1:0]          sync_sel,
  input logic                sync_in,
  input logic [DATA_W-1:0]   cnt,
  input logic [DATA_W-1:0]   per_act,
  input logic [DATA_W-1:0]   per_sh,
  input logic                pwm_out
);
  logic wr_pa;
  assign wr_pa = wr && (addr == ADDR_W'(OFF_PER_ACT));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt));

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt < per_act && !(sync_in && sync_sel != 2'b11)) |=> cnt == $past(cnt) + 1'b1);

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt >= per_act) |=> cnt == '0);

  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt >= per_act && !wr_pa) |=> per_act == $past(per_sh));

  p_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!(run && cnt >= per_act) && !wr_pa) |=> $stable(per_act));

  p_off_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_en |-> !pwm_out);

  p_direct_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pa && &strb) |=> (per_act == $past(wdata)) && (per_sh == $past(wdata)));

  p_sync_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sync_in && sync_sel != 2'b11) |=> cnt == '0);
endmodule

bind aux_pwm_timer aux_pwm_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .addr(bus_addr), .wr(bus_wr), .strb(bus_strb),
  .wdata(bus_wdata), .run(run), .pwm_en(pwm_en), .sync_sel(sync_sel),
  .sync_in(sync_in), .cnt(cnt), .per_act(per_act), .per_sh(per_sh), .pwm_out(pwm_out)
);

// File: tb/aux_pwm_timer_tb.sv
module aux_pwm_timer_tb;
  logic        clk, rst_n, bus_wr, sync_in;
  logic [7:0]  bus_addr;
  logic [3:0]  bus_strb;
  logic [31:0] bus_wdata, bus_rdata;
  logic        pwm_out;
  int checks, errors;

  aux_pwm_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_strb(bus_strb), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sync_in(sync_in), .pwm_out(pwm_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {period[7:0], compare[7:0], invert}
  localparam logic [16:0] VEC [0:6] = '{
    {8'd4, 8'd2, 1'b0},   // R5 plain duty
    {8'd5, 8'd0, 1'b0},   // R5 compare zero: always low
    {8'd3, 8'd3, 1'b0},   // R5 compare equals period: always high
    {8'd6, 8'd8, 1'b0},   // R5 compare above period
    {8'd4, 8'd1, 1'b1},   // R6 inverted
    {8'd1, 8'd1, 1'b0},   // R11 minimum
    {8'd7, 8'd5, 1'b1}    // R6 inverted
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
    bus_addr = a; bus_wdata = d; bus_strb = s; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, c1;
    checks = 0; errors = 0;
    bus_wr = 0; bus_addr = 0; bus_strb = 0; bus_wdata = 0; sync_in = 0; rst_n = 1;
    @(negedge clk);
    do_reset();

    // R1 reset state
    for (int a = 0; a <= 'h14; a += 4) begin
      rd(8'(a), d); chk("R1 reg after reset", d, 0);
    end
    chk("R1 output low", {31'b0, pwm_out}, 0);
    @(negedge clk); rd(8'h14, d); chk("R1 counter stopped", d, 0);

    // R2 byte lanes, control mask, unmapped
    wr(8'h0C, 32'hAABBCCDD, 4'hF);
    wr(8'h0C, 32'h11223344, 4'b0011);
    rd(8'h0C, d); chk("R2 byte lanes", d, 32'hAABB3344);
    wr(8'h0C, 32'h99000000, 4'b1000);
    rd(8'h0C, d); chk("R2 top lane", d, 32'h99BB3344);
    wr(8'h00, 32'hFFFF_FFCA, 4'hF);
    rd(8'h00, d); chk("R2 control mask", d, 32'h0000_0002);
    rd(8'h20, d); chk("R2 unmapped", d, 0);

    // R9 direct active write also sets shadow
    do_reset();
    wr(8'h04, 32'd7, 4'hF);
    rd(8'h04, d); chk("R9 active period", d, 7);
    rd(8'h0C, d); chk("R9 shadow period", d, 7);
    wr(8'h08, 32'd3, 4'hF);
    rd(8'h10, d); chk("R9 shadow compare", d, 3);

    // Vector table: R4, R5, R6, R11
    foreach (VEC[i]) begin
      int p, c, e;
      logic inv, exp_o;
      p = int'(VEC[i][16:9]); c = int'(VEC[i][8:1]); inv = VEC[i][0];
      do_reset();
      wr(8'h04, 32'(p), 4'hF);
      wr(8'h08, 32'(c), 4'hF);
      wr(8'h00, {29'b0, inv, 2'b11}, 4'hF);
      e = 0;
      for (int k = 0; k < 2 * (p + 1); k++) begin
        exp_o = ((c >= p) || (e < c)) ^ inv;
        rd(8'h14, d); chk("R4 counter sequence", d, 32'(e));
        chk(p == 1 ? "R11 minimum output" : (inv ? "R6 inverted output" : "R5 output"),
            {31'b0, pwm_out}, {31'b0, exp_o});
        @(negedge clk);
        e = (e == p) ? 0 : e + 1;
      end
    end

    // R3 hold while stopped
    wr(8'h00, 32'h2, 4'hF);
    rd(8'h14, c1);
    repeat (5) @(negedge clk);
    rd(8'h14, d); chk("R3 counter holds", d, c1);

    // R7 output disabled, even when inverted and running
    wr(8'h00, 32'h5, 4'hF);
    for (int k = 0; k < 10; k++) begin
      chk("R7 disabled output low", {31'b0, pwm_out}, 0);
      @(negedge clk);
    end

    // R8 shadow update at boundary
    do_reset();
    wr(8'h04, 32'd9, 4'hF);
    wr(8'h08, 32'd3, 4'hF);
    wr(8'h00, 32'h3, 4'hF);             // cnt 0
    repeat (3) @(negedge clk);          // cnt 3
    wr(8'h0C, 32'd4, 4'hF);             // cnt 4
    wr(8'h10, 32'd1, 4'hF);             // cnt 5
    rd(8'h04, d); chk("R8 active period kept", d, 9);
    chk("R8 old compare in force", {31'b0, pwm_out}, 0);
    repeat (4) @(negedge clk);          // cnt 9
    rd(8'h14, d); chk("R8 old period completes", d, 9);
    rd(8'h08, d); chk("R8 active compare kept", d, 3);
    @(negedge clk);                     // wrapped
    rd(8'h04, d); chk("R8 period loaded at wrap", d, 4);
    rd(8'h08, d); chk("R8 compare loaded at wrap", d, 1);
    chk("R8 new duty high", {31'b0, pwm_out}, 1);
    @(negedge clk);
    chk("R8 new duty low", {31'b0, pwm_out}, 0);
    repeat (3) @(negedge clk);          // cnt 4
    rd(8'h14, d); chk("R8 new period end", d, 4);
    @(negedge clk);
    rd(8'h14, d); chk("R8 new period wraps", d, 0);

    // R10 sync ignored when disabled, honoured otherwise
    do_reset();
    wr(8'h04, 32'd50, 4'hF);
    wr(8'h00, 32'h33, 4'hF);            // run, enable, sync disabled
    repeat (5) @(negedge clk);
    rd(8'h14, c1);
    sync_in = 1'b1; @(negedge clk); sync_in = 1'b0;
    rd(8'h14, d); chk("R10 sync ignored", d, c1 + 1);
    wr(8'h00, 32'h03, 4'hF);
    rd(8'h14, d); chk("R10 counter before sync", d, c1 + 2);
    sync_in = 1'b1; @(negedge clk); sync_in = 1'b0;
    rd(8'h14, d); chk("R10 sync clears", d, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule